// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits at the head of a receive path and decides, from the six destination address bytes of an incoming frame, whether the frame is wanted. The bytes arrive one per valid cycle, and the first byte of each frame is flagged. While they arrive, the block runs the Ethernet CRC-32 over them. It then takes an 8-bit index from the bit-reversed CRC and uses it to look up one bit of a 256-entry group hash table.

Individual (unicast) addresses are accepted only when they equal the programmed station address. The all-ones broadcast address is always accepted. Other group addresses are accepted when their hash bit is set. A promiscuous control bit accepts every frame. The hash table, the station address and the control bit sit behind a simple single-cycle register write port with a combinational read port.

Top module: `mac_da_filter`

## Requirements
- R1: After reset, every register reads zero (hash table empty, station address zero, promiscuous off) and `decision_valid_o` is low.
- R2: The register map is as follows.
  - Addresses 0 to 7 are the hash words and hold all 32 bits.
  - Address 8 is control: bit 0 is promiscuous, and the other bits read zero.
  - Address 9 holds station bytes {5,4,3,2} from bit 31 down.
  - Address 10 holds station bytes {1,0} in bits 31:16, and bits 15:0 read zero.
  - Other addresses read zero, and writes to them have no effect.
- R3: The CRC register starts at all ones. Each byte is fed least significant bit first, with the reflected polynomial 0xEDB88320 and no final inversion. The index is the bit-reversed low byte of the result: index bit 7 is CRC bit 0, and index bit 0 is CRC bit 7. This equals the top 8 bits of the non-reflected CRC.
- R4: Index bits 7:5 pick the hash word. Index bits 4:0, written b, pick bit 31−b of that word, so word 0 bit 31 is entry 0 and word 7 bit 0 is entry 255.
- R5: A group address is one with bit 0 of the first byte set. A group address other than broadcast is accepted exactly when its hash bit is set, so it is rejected while the table is empty.
- R6: The broadcast address (all 48 bits one) is accepted whatever the hash table holds.
- R7: An individual address (first byte bit 0 clear) is accepted exactly when all six bytes equal the station address. Byte 0 is the first byte received.
- R8: While promiscuous is set, every frame is accepted.
- R9: `decision_valid_o` rises on the clock edge that samples the sixth address byte. It stays high, with `accept_o` unchanged, until a frame-start byte is sampled. It is low after that edge.
- R10: Bytes after the sixth of a frame, and bytes that arrive without a preceding frame start, do not change the decision.
- R11: Idle cycles between address bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address (write and read) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| rx_valid_i | input | 1 | Address byte valid |
| rx_sof_i | input | 1 | Marks the valid byte as the first of a frame |
| rx_byte_i | input | 8 | Address byte |
| decision_valid_o | output | 1 | Decision for the current frame is available |
| accept_o | output | 1 | Frame accepted |

## Verification
The hardest case to reach is the hash word and bit mapping. A random group address lands on one of 256 entries, and unless only that one bit is set, a wrong word or a mirrored bit position can still hit. The bench therefore computes the index of a chosen group address with its own CRC model, a non-reflected MSB-first form. It then writes only the predicted bit and expects acceptance. Next it writes the complement of that bit and fills every other word with ones, and expects rejection. Gapped byte streams and bytes arriving after the decision, or without a frame start, are driven so that the hold behaviour is checked.

// File: rtl/da_filt_pkg.sv
package da_filt_pkg;
  localparam int REG_W    = 32;
  localparam int DA_BYTES = 6;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

  // one byte, lsb first, reflected register
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/da_crc_unit.sv
module da_crc_unit
  import da_filt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_next_o
);
  logic [31:0] crc_q;

  assign crc_next_o = crc_step(start_i ? CRC_PRESET : crc_q, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_PRESET;
    else if (en_i) crc_q <= crc_next_o;
  end

  // R3: running CRC only advances on accepted bytes
  p_crc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(crc_q));
endmodule

// File: rtl/da_filt_regs.sv
module da_filt_regs
  import da_filt_pkg::*;
#(
  parameter int NUM_HASH_REGS = 8,
  parameter int REG_AW        = 4,
  localparam int TBL_N        = NUM_HASH_REGS * REG_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  output logic [TBL_N-1:0]              table_o,
  output logic [DA_BYTES-1:0][7:0]      station_o,
  output logic                          promisc_o
);
  localparam int HSEL_W = $clog2(NUM_HASH_REGS);
  localparam logic [REG_AW-1:0] HASH_END = REG_AW'(NUM_HASH_REGS);
  localparam logic [REG_AW-1:0] CTRL_A   = REG_AW'(NUM_HASH_REGS);
  localparam logic [REG_AW-1:0] STA_A    = REG_AW'(NUM_HASH_REGS + 1);
  localparam logic [REG_AW-1:0] STA_B    = REG_AW'(NUM_HASH_REGS + 2);

  logic [NUM_HASH_REGS-1:0][REG_W-1:0] hash_q;
  logic [31:0] sta_a_q;
  logic [15:0] sta_b_q;
  logic        promisc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_q    <= '0;
      sta_a_q   <= '0;
      sta_b_q   <= '0;
      promisc_q <= 1'b0;
    end else if (we_i) begin
      for (int r = 0; r < NUM_HASH_REGS; r++)
        if (addr_i == REG_AW'(r)) hash_q[r] <= wdata_i;
      if (addr_i == CTRL_A) promisc_q <= wdata_i[0];
      if (addr_i == STA_A)  sta_a_q   <= wdata_i;
      if (addr_i == STA_B)  sta_b_q   <= wdata_i[31:16];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < HASH_END)    rdata_o = hash_q[addr_i[HSEL_W-1:0]];
    else if (addr_i == CTRL_A) rdata_o = {{(REG_W-1){1'b0}}, promisc_q};
    else if (addr_i == STA_A)  rdata_o = sta_a_q;
    else if (addr_i == STA_B)  rdata_o = {sta_b_q, 16'h0};
  end

  // msb-first numbering: entry e lives at word e/32, bit 31-(e%32)
  for (genvar e = 0; e < TBL_N; e++) begin : g_tbl
    assign table_o[e] = hash_q[e / REG_W][REG_W - 1 - (e % REG_W)];
  end

  assign station_o[0] = sta_b_q[7:0];
  assign station_o[1] = sta_b_q[15:8];
  assign station_o[2] = sta_a_q[7:0];
  assign station_o[3] = sta_a_q[15:8];
  assign station_o[4] = sta_a_q[23:16];
  assign station_o[5] = sta_a_q[31:24];
  assign promisc_o    = promisc_q;

  // R2: table only changes on a write
  p_table_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(hash_q));
  // R2: control bit only changes on a write
  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(promisc_q));
endmodule

// File: rtl/mac_da_filter.sv
module mac_da_filter
  import da_filt_pkg::*;
#(
  parameter int NUM_HASH_REGS = 8,
  parameter int REG_AW        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic [7:0]        rx_byte_i,
  output logic              decision_valid_o,
  output logic              accept_o
);
  localparam int TBL_N = NUM_HASH_REGS * REG_W;
  localparam int IDX_W = $clog2(TBL_N);
  localparam int CNT_W = $clog2(DA_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(DA_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DA_BYTES - 1);

  logic [TBL_N-1:0]             tbl;
  logic [DA_BYTES-1:0][7:0]     station, da_q, da_cur;
  logic                         promisc;
  logic [31:0]                  crc_next;
  logic [CNT_W-1:0]             cnt_q, pos;
  logic                         take, last, sof_take;
  logic [IDX_W-1:0]             hash_idx;
  logic                         grp, bcast, uni_hit, hash_hit, accept_d;
  logic                         valid_q, accept_q;

  da_filt_regs #(.NUM_HASH_REGS(NUM_HASH_REGS), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .table_o(tbl), .station_o(station), .promisc_o(promisc)
  );

  assign take     = rx_valid_i && (rx_sof_i || cnt_q < CNT_IDLE);
  assign sof_take = rx_valid_i && rx_sof_i;
  assign pos      = rx_sof_i ? '0 : cnt_q;
  assign last     = take && (pos == CNT_LAST);

  da_crc_unit u_crc (
    .clk_i, .rst_ni,
    .start_i(rx_sof_i), .en_i(take), .byte_i(rx_byte_i), .crc_next_o(crc_next)
  );

  always_comb begin
    da_cur = da_q;
    if (take) da_cur[pos] = rx_byte_i;
  end

  // index = bit-reversed low bits of the reflected CRC
  for (genvar i = 0; i < IDX_W; i++) begin : g_idx
    assign hash_idx[i] = crc_next[IDX_W - 1 - i];
  end

  assign grp      = da_cur[0][0];
  assign bcast    = &da_cur;
  assign uni_hit  = (da_cur == station);
  assign hash_hit = tbl[hash_idx];
  assign accept_d = promisc | (grp ? (bcast | hash_hit) : uni_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_IDLE;
      da_q     <= '0;
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else if (take) begin
      cnt_q   <= pos + 1'b1;
      da_q    <= da_cur;
      valid_q <= last;
      if (last)          accept_q <= accept_d;
      else if (sof_take) accept_q <= 1'b0;
    end
  end

  assign decision_valid_o = valid_q;
  assign accept_o         = accept_q;

  // R9: frame start withdraws the previous decision
  p_sof_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_take |=> !decision_valid_o);
  // R9 / R10: decision holds until the next frame start
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o && !sof_take |=> decision_valid_o && $stable(accept_o));
  // R8: promiscuous forces acceptance
  p_promisc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decision_valid_o) && $past(promisc) |-> accept_o);
endmodule

// File: tb/mac_da_filter_test.sv
module mac_da_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dvalid, acc;

  int checks = 0, fails = 0;
  logic [31:0] tbl_m [8];
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

  always #5 clk = ~clk;

  mac_da_filter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_byte_i(rx_byte),
    .decision_valid_o(dvalid), .accept_o(acc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    summary();
    $finish;
  end

  // non-reflected, msb-first form of the CRC
  function automatic logic [7:0] idx_of(input logic [47:0] da);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0] o;
    logic m;
    for (int i = 0; i < 6; i++) begin
      o = da[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        m = c[31] ^ o[0];
        c = c << 1;
        if (m) c = c ^ 32'h04C11DB7;
        o = o >> 1;
      end
    end
    return c[31:24];
  endfunction

  function automatic logic exp_acc(input logic [47:0] da, input logic p);
    logic [7:0] k;
    if (p) return 1'b1;
    if (da[40]) begin
      if (da == '1) return 1'b1;
      k = idx_of(da);
      return tbl_m[k[7:5]][31 - k[4:0]];
    end
    return da == STA;
  endfunction

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic s);
    rx_valid = 1'b1; rx_sof = s; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic send_da(input logic [47:0] da, input int gap, input logic with_sof);
    for (int i = 0; i < 6; i++) begin
      send_byte(da[47 - 8*i -: 8], with_sof && i == 0);
      repeat (gap) @(negedge clk);
      if (with_sof && i == 4) chk("R9 valid low before sixth byte", {31'b0, dvalid}, 32'd0);
    end
  endtask

  task automatic set_hash_bit_only(input logic [7:0] k);
    for (int r = 0; r < 8; r++) begin
      tbl_m[r] = (r == int'(k[7:5])) ? (32'h1 << (31 - k[4:0])) : 32'h0;
      reg_wr(4'(r), tbl_m[r]);
    end
  endtask

  localparam int NV = 12;
  // {promiscuous, destination address}
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 48'h01005e000001}, {1'b0, 48'h333300000001}, {1'b0, 48'h01005e7ffffa},
    {1'b0, 48'hffffffffffff}, {1'b0, 48'h021122334455}, {1'b0, 48'h021122334454},
    {1'b0, 48'h0a0b0c0d0e0f}, {1'b0, 48'h030000000000}, {1'b1, 48'h0a0b0c0d0e0f},
    {1'b1, 48'h01005e7ffffa}, {1'b1, 48'h021122334454}, {1'b0, 48'hffffffffffff}
  };

  initial begin
    logic [31:0] d;
    logic [7:0]  k;
    logic [47:0] mc;
    string       tag;
    for (int r = 0; r < 8; r++) tbl_m[r] = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 valid after reset", {31'b0, dvalid}, 32'd0);
    for (int a = 0; a < 11; a++) begin
      reg_rd(4'(a), d);
      chk("R1 register reset value", d, 32'd0);
    end

    // R2 register map
    reg_wr(4'd3, 32'hA5C3_0F96);
    reg_rd(4'd3, d); chk("R2 hash word readback", d, 32'hA5C3_0F96);
    reg_wr(4'd8, 32'hFFFF_FFFE);
    reg_rd(4'd8, d); chk("R2 control bits", d, 32'd0);
    reg_wr(4'd10, 32'hFFFF_FFFF);
    reg_rd(4'd10, d); chk("R2 station word B low half", d, 32'hFFFF_0000);
    reg_wr(4'd11, 32'h1234_5678);
    reg_rd(4'd11, d); chk("R2 unmapped address", d, 32'd0);
    reg_rd(4'd3, d);  chk("R2 unmapped write no effect", d, 32'hA5C3_0F96);
    reg_wr(4'd3, 32'h0);

    // R5 empty table rejects group address
    send_da(48'h01005e000001, 0, 1'b1);
    chk("R5 valid", {31'b0, dvalid}, 32'd1);
    chk("R5 empty table rejects", {31'b0, acc}, 32'd0);

    // R3/R4 exact bit mapping
    mc = 48'h01005e0000fb;
    k = idx_of(mc);
    set_hash_bit_only(k);
    send_da(mc, 0, 1'b1);
    chk("R3 R4 single predicted bit accepts", {31'b0, acc}, 32'd1);
    for (int r = 0; r < 8; r++) begin
      tbl_m[r] = (r == int'(k[7:5])) ? ~(32'h1 << (31 - k[4:0])) : 32'hFFFF_FFFF;
      reg_wr(4'(r), tbl_m[r]);
    end
    send_da(mc, 0, 1'b1);
    chk("R4 all but predicted bit rejects", {31'b0, acc}, 32'd0);
    for (int r = 0; r < 8; r++) begin tbl_m[r] = '0; reg_wr(4'(r), 32'h0); end

    // program station and two group entries
    reg_wr(4'd9,  {STA[7:0], STA[15:8], STA[23:16], STA[31:24]});
    reg_wr(4'd10, {STA[39:32], STA[47:40], 16'h0});
    reg_rd(4'd9, d); chk("R2 station word A", d, 32'h5544_3322);
    k = idx_of(48'h01005e000001); tbl_m[k[7:5]] |= 32'h1 << (31 - k[4:0]);
    k = idx_of(48'h333300000001); tbl_m[k[7:5]] |= 32'h1 << (31 - k[4:0]);
    for (int r = 0; r < 8; r++) reg_wr(4'(r), tbl_m[r]);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      reg_wr(4'd8, {31'b0, VEC[v][48]});
      send_da(VEC[v][47:0], 0, 1'b1);
      if (VEC[v][48])               tag = "R8 promiscuous";
      else if (VEC[v][47:0] == '1)  tag = "R6 broadcast";
      else if (VEC[v][40])          tag = "R5 R3 group hash";
      else                          tag = "R7 unicast";
      chk("R9 valid after sixth byte", {31'b0, dvalid}, 32'd1);
      chk(tag, {31'b0, acc}, {31'b0, exp_acc(VEC[v][47:0], VEC[v][48])});
    end
    reg_wr(4'd8, 32'h0);

    // R10 trailing bytes and bytes without frame start
    send_da(48'h0a0b0c0d0e0f, 0, 1'b1);
    chk("R7 mismatch rejects", {31'b0, acc}, 32'd0);
    for (int i = 0; i < 4; i++) send_byte(8'hFF, 1'b0);
    chk("R10 trailing bytes keep valid", {31'b0, dvalid}, 32'd1);
    chk("R10 trailing bytes keep decision", {31'b0, acc}, 32'd0);
    send_da(48'hffffffffffff, 0, 1'b0);
    chk("R10 bytes without frame start ignored", {31'b0, acc}, 32'd0);
    chk("R10 valid held", {31'b0, dvalid}, 32'd1);

    // R9 frame start clears valid
    send_byte(8'h02, 1'b1);
    chk("R9 frame start clears valid", {31'b0, dvalid}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 stays low mid address", {31'b0, dvalid}, 32'd0);

    // R11 gapped bytes
    send_da(STA, 3, 1'b1);
    chk("R11 gapped valid", {31'b0, dvalid}, 32'd1);
    chk("R11 gapped station accepted", {31'b0, acc}, 32'd1);
    send_da(48'h333300000001, 2, 1'b1);
    chk("R11 gapped group accepted", {31'b0, acc}, 32'd1);

    summary();
    $finish;
  end
endmodule